// File: doc/BRIEF.md
# Warp Scheduler with Stall Mask

This block chooses, every cycle, which warp of a multi-warp SIMT core sends its next instruction to fetch. It holds two masks. The active mask says which warps are running. The stall mask says which warps already have an instruction between fetch and decode. A warp can be chosen only when it is active and not stalled. Among those warps the lowest index wins. The chosen warp's index and program counter go out on a valid/ready stream to fetch. When fetch accepts them, the warp is marked stalled and its program counter steps by 4.

Decode reports back through a release input. A release lowers the named warp's stall bit, unless the instruction is marked as a fetch stall. A release may also load a new program counter into that warp.

Several plain control inputs act on the masks. A spawn command wakes warps 1 and up at a shared program counter. Resume clears every stall bit at once. An exit event puts every warp to sleep. A free-running counter records the cycles on which no warp could be offered.

Back-pressure rules for the issue stream:
- `issue_valid` depends only on the registered masks, never on `issue_ready`.
- A transfer happens on a clock edge where both `issue_valid` and `issue_ready` are high.
- While ready is low, the offered warp, its program counter and the stall mask stay put, apart from changes made by the control inputs.

Top module: `wsched_top`

## Requirements
- R1: `issue_valid` is high exactly when some warp is both active and not stalled. `issue_wid` is then the lowest such index, and `issue_pc` is that warp's program counter.
- R2: With `issue_valid` high and `issue_ready` low, the offered warp is not stalled and its program counter does not change. The same warp and program counter are offered on the next cycle, provided no control input acts.
- R3: On a transfer, the chosen warp's stall bit is set at that edge. The warp is not offered again until a release or a resume clears the bit.
- R4: A release with `rel_fetch_stall` low clears the stall bit of warp `rel_wid`. With `rel_fetch_stall` high, the stall bit is left set.
- R5: A transfer adds 4 to the chosen warp's program counter. A release with `rel_pc_valid` high loads `rel_pc` into warp `rel_wid`.
- R6: After reset, only warp 0 is active (`active_mask` = 1), only warp 0 has thread 0 enabled (`thread0_en` = 1), and no warp is stalled. Every program counter equals `RESET_PC` and `idle_count` is 0.
- R7: A spawn with count n and program counter p does three things to each warp i with 1 <= i < min(n, NW): it sets the active bit, loads p as the program counter, and sets bit i of `thread0_en`. Warp 0 is never changed by a spawn. A count of 0 or 1 changes nothing.
- R8: `resume` clears the whole stall mask.
- R9: `exit_evt` clears the whole active mask at the next edge. It leaves `thread0_en` as it is.
- R10: `idle_count` increments by one (wrapping) on each cycle where `issue_valid` is low.
- R11: When signals collide in the same cycle, the following take precedence:
  - a transfer's stall set beats a resume or release;
  - an exit beats a spawn;
  - a spawn's program-counter load beats a release load, which beats the step of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | output | 1 | A warp is offered to fetch |
| issue_ready | input | 1 | Fetch accepts the offered warp |
| issue_wid | output | WID_W | Index of the offered warp |
| issue_pc | output | PC_W | Program counter of the offered warp |
| rel_valid | input | 1 | Decode releases warp `rel_wid` |
| rel_wid | input | WID_W | Warp being released |
| rel_fetch_stall | input | 1 | Released instruction is a fetch stall; keep the stall bit |
| rel_pc_valid | input | 1 | Load `rel_pc` into the released warp |
| rel_pc | input | PC_W | New program counter from decode |
| spawn_valid | input | 1 | Spawn command |
| spawn_count | input | CNT_W | Number of warps the spawn should leave running |
| spawn_pc | input | PC_W | Start program counter for spawned warps |
| resume | input | 1 | Clear every stall bit |
| exit_evt | input | 1 | Deactivate every warp |
| active_mask | output | NW | Active warps |
| thread0_en | output | NW | Thread 0 enable per warp |
| idle_count | output | IDLE_W | Cycles with no warp offered |

## Verification
The assertions check the following on every cycle:
- the offered warp is active, unstalled and the lowest such index;
- a transfer stalls that warp at the next edge;
- a stalled handshake leaves the stall mask unchanged;
- a resume empties the stall mask and an exit empties the active mask;
- the idle counter steps on exactly the cycles where nothing is offered.

Some behaviour only the bench's scenarios can show:
- program counter arithmetic: the step of 4, loads from decode and loads from spawn;
- the fetch-stall flag keeping a warp blocked;
- the spawn range limits, including counts of 0, 1 and above the warp count;
- the precedence rules when several control inputs arrive in the same cycle.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  localparam int unsigned PC_STEP = 4;

  typedef enum logic [1:0] {
    PCW_HOLD  = 2'd0,
    PCW_STEP  = 2'd1,
    PCW_REL   = 2'd2,
    PCW_SPAWN = 2'd3
  } pc_wr_e;
endpackage

// File: rtl/wsched_pick.sv
module wsched_pick #(
  parameter int NW = 8,
  localparam int WID_W = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic [NW-1:0]    cand,
  output logic             any,
  output logic [WID_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      if (cand[i]) idx = WID_W'(i);
    end
  end

  assign any = |cand;
endmodule

// File: rtl/wsched_masks.sv
module wsched_masks #(
  parameter int NW    = 8,
  parameter int CNT_W = 8,
  localparam int WID_W = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [WID_W-1:0] sel,
  input  logic             rel_valid,
  input  logic [WID_W-1:0] rel_wid,
  input  logic             rel_fetch_stall,
  input  logic             spawn_valid,
  input  logic [CNT_W-1:0] spawn_count,
  input  logic             resume,
  input  logic             exit_evt,
  output logic [NW-1:0]    spawn_hit,
  output logic [NW-1:0]    active_q,
  output logic [NW-1:0]    stall_q,
  output logic [NW-1:0]    t0_q
);
  logic [NW-1:0] active_d, stall_d;

  for (genvar i = 0; i < NW; i++) begin : g_spawn
    if (i == 0) begin : g_w0
      assign spawn_hit[i] = 1'b0;
    end else begin : g_wn
      assign spawn_hit[i] = spawn_valid && (int'(spawn_count) > i);
    end
  end

  always_comb begin
    active_d = exit_evt ? '0 : (active_q | spawn_hit);
    stall_d  = stall_q;
    if (resume) stall_d = '0;
    else if (rel_valid && !rel_fetch_stall) stall_d[rel_wid] = 1'b0;
    if (fire) stall_d[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= NW'(1);
      stall_q  <= '0;
      t0_q     <= NW'(1);
    end else begin
      active_q <= active_d;
      stall_q  <= stall_d;
      t0_q     <= t0_q | spawn_hit;
    end
  end
endmodule

// File: rtl/wsched_pcfile.sv
module wsched_pcfile
  import wsched_pkg::*;
#(
  parameter int          NW       = 8,
  parameter int          PC_W     = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  localparam int WID_W = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [WID_W-1:0] sel,
  input  logic             rel_load,
  input  logic [WID_W-1:0] rel_wid,
  input  logic [PC_W-1:0]  rel_pc,
  input  logic [NW-1:0]    spawn_hit,
  input  logic [PC_W-1:0]  spawn_pc,
  output logic [PC_W-1:0]  pc_sel
);
  logic [PC_W-1:0] pc_q [NW];

  for (genvar i = 0; i < NW; i++) begin : g_pc
    pc_wr_e src;
    always_comb begin
      if (spawn_hit[i])                               src = PCW_SPAWN;
      else if (rel_load && rel_wid == WID_W'(i))      src = PCW_REL;
      else if (fire && sel == WID_W'(i))              src = PCW_STEP;
      else                                            src = PCW_HOLD;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) pc_q[i] <= PC_W'(RESET_PC);
      else begin
        unique case (src)
          PCW_SPAWN: pc_q[i] <= spawn_pc;
          PCW_REL:   pc_q[i] <= rel_pc;
          PCW_STEP:  pc_q[i] <= pc_q[i] + PC_W'(PC_STEP);
          default:   pc_q[i] <= pc_q[i];
        endcase
      end
    end
  end

  assign pc_sel = pc_q[sel];
endmodule

// File: rtl/wsched_top.sv
module wsched_top #(
  parameter int          NW       = 8,
  parameter int          PC_W     = 32,
  parameter int          CNT_W    = 8,
  parameter int          IDLE_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  localparam int WID_W = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              issue_valid,
  input  logic              issue_ready,
  output logic [WID_W-1:0]  issue_wid,
  output logic [PC_W-1:0]   issue_pc,
  input  logic              rel_valid,
  input  logic [WID_W-1:0]  rel_wid,
  input  logic              rel_fetch_stall,
  input  logic              rel_pc_valid,
  input  logic [PC_W-1:0]   rel_pc,
  input  logic              spawn_valid,
  input  logic [CNT_W-1:0]  spawn_count,
  input  logic [PC_W-1:0]   spawn_pc,
  input  logic              resume,
  input  logic              exit_evt,
  output logic [NW-1:0]     active_mask,
  output logic [NW-1:0]     thread0_en,
  output logic [IDLE_W-1:0] idle_count
);
  logic [NW-1:0]     spawn_hit, active_q, stall_q, t0_q, cand;
  logic [WID_W-1:0]  sel;
  logic              any, fire;
  logic [IDLE_W-1:0] idle_q;

  assign cand = active_q & ~stall_q;
  assign fire = any && issue_ready;

  wsched_pick #(.NW(NW)) u_pick (
    .cand (cand),
    .any  (any),
    .idx  (sel)
  );

  wsched_masks #(.NW(NW), .CNT_W(CNT_W)) u_masks (
    .clk             (clk),
    .rst_n           (rst_n),
    .fire            (fire),
    .sel             (sel),
    .rel_valid       (rel_valid),
    .rel_wid         (rel_wid),
    .rel_fetch_stall (rel_fetch_stall),
    .spawn_valid     (spawn_valid),
    .spawn_count     (spawn_count),
    .resume          (resume),
    .exit_evt        (exit_evt),
    .spawn_hit       (spawn_hit),
    .active_q        (active_q),
    .stall_q         (stall_q),
    .t0_q            (t0_q)
  );

  wsched_pcfile #(.NW(NW), .PC_W(PC_W), .RESET_PC(RESET_PC)) u_pcs (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .sel       (sel),
    .rel_load  (rel_valid && rel_pc_valid),
    .rel_wid   (rel_wid),
    .rel_pc    (rel_pc),
    .spawn_hit (spawn_hit),
    .spawn_pc  (spawn_pc),
    .pc_sel    (issue_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)   idle_q <= '0;
    else if (!any) idle_q <= idle_q + 1'b1;
  end

  assign issue_valid = any;
  assign issue_wid   = sel;
  assign active_mask = active_q;
  assign thread0_en  = t0_q;
  assign idle_count  = idle_q;
endmodule

// File: rtl/wsched_chk.sv
module wsched_chk #(
  parameter int NW     = 8,
  parameter int IDLE_W = 32,
  localparam int WID_W = (NW > 1) ? $clog2(NW) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic              issue_ready,
  input logic [WID_W-1:0]  issue_wid,
  input logic              rel_valid,
  input logic              resume,
  input logic              exit_evt,
  input logic [NW-1:0]     active_mask,
  input logic [NW-1:0]     stall,
  input logic [IDLE_W-1:0] idle_count
);
  logic [NW-1:0] below, free;
  assign free = active_mask & ~stall;
  always_comb begin
    below = '0;
    for (int i = 0; i < NW; i++) if (i < int'(issue_wid)) below[i] = 1'b1;
  end

  AST_PICK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (active_mask[issue_wid] && !stall[issue_wid])); // R1
  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ((free & below) == '0)); // R1
  AST_OFFER_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (free != '0) |-> issue_valid); // R1
  AST_HOLD_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready && !resume && !rel_valid) |=> $stable(stall)); // R2
  AST_STALL_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready) |=> stall[$past(issue_wid)]); // R3
  AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && !(issue_valid && issue_ready)) |=> (stall == '0)); // R8
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> (active_mask == '0)); // R9
  AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> (idle_count == IDLE_W'($past(idle_count) + 1'b1))); // R10
endmodule

bind wsched_top wsched_chk #(.NW(NW), .IDLE_W(IDLE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .issue_ready (issue_ready),
  .issue_wid   (issue_wid),
  .rel_valid   (rel_valid),
  .resume      (resume),
  .exit_evt    (exit_evt),
  .active_mask (active_mask),
  .stall       (stall_q),
  .idle_count  (idle_count)
);

// File: tb/sim_wsched_top.sv
module sim_wsched_top;
  localparam int PERIOD = 10;
  localparam int NW = 4, PC_W = 32, CNT_W = 8, IDLE_W = 32, WID_W = 2;
  localparam logic [31:0] RPC = 32'h100;

  logic clk = 0, rst_n = 0;
  logic issue_valid, issue_ready;
  logic [WID_W-1:0] issue_wid, rel_wid;
  logic [PC_W-1:0] issue_pc, rel_pc, spawn_pc;
  logic rel_valid, rel_fetch_stall, rel_pc_valid, spawn_valid, resume, exit_evt;
  logic [CNT_W-1:0] spawn_count;
  logic [NW-1:0] active_mask, thread0_en;
  logic [IDLE_W-1:0] idle_count;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  wsched_top #(.NW(NW), .PC_W(PC_W), .CNT_W(CNT_W), .IDLE_W(IDLE_W), .RESET_PC(RPC)) u0 (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_wid(issue_wid), .issue_pc(issue_pc), .rel_valid(rel_valid), .rel_wid(rel_wid),
    .rel_fetch_stall(rel_fetch_stall), .rel_pc_valid(rel_pc_valid), .rel_pc(rel_pc),
    .spawn_valid(spawn_valid), .spawn_count(spawn_count), .spawn_pc(spawn_pc),
    .resume(resume), .exit_evt(exit_evt), .active_mask(active_mask),
    .thread0_en(thread0_en), .idle_count(idle_count));

  typedef struct packed {
    logic rdy; logic rv; logic [1:0] rw; logic rf; logic rpv; logic [31:0] rpc;
    logic sv; logic [7:0] sc; logic [31:0] spc; logic res; logic ext;
    logic ev; logic [1:0] ew; logic [31:0] epc; logic [3:0] eact;
  } vec_t;

  // inputs applied this cycle | outputs expected before the edge
  localparam vec_t TBL [14] = '{
    '{1,0,0,0,0,0, 0,0,0, 0,0, 1,0,32'h100,4'h1},      // R1 warp0 offered
    '{1,0,0,0,0,0, 1,3,32'h200, 0,0, 0,0,0,4'h1},      // R3 R7 R10 w0 stalled, spawn 3
    '{1,0,0,0,0,0, 0,0,0, 0,0, 1,1,32'h200,4'h7},      // R7 w1 at spawn pc
    '{0,1,0,0,0,0, 0,0,0, 0,0, 1,2,32'h200,4'h7},      // R2 R4 ready low, release w0
    '{1,0,0,0,0,0, 0,0,0, 0,0, 1,0,32'h104,4'h7},      // R4 R5 w0 back, pc+4
    '{1,1,1,1,0,0, 0,0,0, 0,0, 1,2,32'h200,4'h7},      // R4 fetch-stall release of w1
    '{1,1,1,0,1,32'h300, 0,0,0, 0,0, 0,0,0,4'h7},      // R4 R5 release w1 with new pc
    '{1,0,0,0,0,0, 0,0,0, 1,0, 1,1,32'h300,4'h7},      // R8 R11 resume with issue
    '{1,0,0,0,0,0, 1,9,32'h400, 0,0, 1,0,32'h108,4'h7},// R7 count above NW
    '{1,0,0,0,0,0, 0,0,0, 0,1, 1,2,32'h400,4'hF},      // R9 exit
    '{1,0,0,0,0,0, 0,0,0, 1,0, 0,0,0,4'h0},            // R9 R8 nothing active
    '{1,0,0,0,0,0, 1,2,32'h500, 0,0, 0,0,0,4'h0},      // R7 spawn 2
    '{0,0,0,0,0,0, 0,0,0, 0,0, 1,1,32'h500,4'h2},      // R2 offered, not taken
    '{0,0,0,0,0,0, 0,0,0, 0,0, 1,1,32'h500,4'h2}       // R2 held
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    issue_ready = 0; rel_valid = 0; rel_wid = 0; rel_fetch_stall = 0; rel_pc_valid = 0;
    rel_pc = 0; spawn_valid = 0; spawn_count = 0; spawn_pc = 0; resume = 0; exit_evt = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    do_reset();
    // R6 reset state
    check("R6 valid", issue_valid, 1);
    check("R6 wid", issue_wid, 0);
    check("R6 pc", issue_pc, RPC);
    check("R6 active", active_mask, 4'h1);
    check("R6 thread0", thread0_en, 4'h1);
    check("R6 idle", idle_count, 0);

    for (int k = 0; k < 14; k++) begin
      vec_t v;
      v = TBL[k];
      check("R1 valid", issue_valid, v.ev);
      if (v.ev) begin
        check("R1 wid", issue_wid, v.ew);
        check("R5 pc", issue_pc, v.epc);
      end
      check("R7 active", active_mask, v.eact);
      issue_ready = v.rdy; rel_valid = v.rv; rel_wid = v.rw; rel_fetch_stall = v.rf;
      rel_pc_valid = v.rpv; rel_pc = v.rpc; spawn_valid = v.sv; spawn_count = v.sc;
      spawn_pc = v.spc; resume = v.res; exit_evt = v.ext;
      @(negedge clk);
      idle_inputs();
    end
    check("R10 idle count", idle_count, 4);
    check("R9 thread0 kept", thread0_en, 4'hF);

    // R7 spawn count 1 changes nothing
    do_reset();
    spawn_valid = 1; spawn_count = 1; spawn_pc = 32'h700;
    @(negedge clk); idle_inputs();
    check("R7 count1 active", active_mask, 4'h1);
    check("R7 count1 thread0", thread0_en, 4'h1);

    // R11 exit beats spawn in the same cycle
    spawn_valid = 1; spawn_count = 4; spawn_pc = 32'h700; exit_evt = 1;
    @(negedge clk); idle_inputs();
    check("R11 exit over spawn", active_mask, 4'h0);

    // R11 spawn pc beats release pc for the same warp
    spawn_valid = 1; spawn_count = 2; spawn_pc = 32'h800;
    rel_valid = 1; rel_wid = 1; rel_pc_valid = 1; rel_pc = 32'h900;
    @(negedge clk); idle_inputs();
    check("R11 spawn pc wins", issue_pc, 32'h800);
    check("R7 warp1 only", active_mask, 4'h2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule